// File: doc/BRIEF.md
# Revision Protection Controller for Configuration Flash

This block sits between a serial test-port command decoder and a configuration flash array that holds up to four design revisions. Every command that reaches it carries a 3-bit operation code and a 2-bit revision index. The block rules on each command in the next cycle with a single pulse: either grant or deny. For each revision it keeps a read-protect flag and a lock (write-protect) flag, and it updates them as commands are granted. A lock can be removed in only one way. An unlock command must come first, and the next command must be an erase of the same revision. That erase is then allowed, and it clears both flags of the revision.

A whole-array mode input replaces the per-revision read protection with one global read-protect flag. Only a full-array erase clears that flag. While in-system programming is active, the block forces the cascade-enable output high and withdraws the drive enable of the other configuration outputs, which puts them in high impedance.

The lock sequencing is a two-state machine. `UL_IDLE` means no unlock is pending. `UL_ARMED` means an unlock was accepted and its revision is remembered. The machine changes state only on cycles that carry a command. The transition `arm` (IDLE to ARMED, and ARMED to ARMED) is taken on any UNLOCK. The transition `disarm` (ARMED to IDLE) is taken on any other command. Whether that command was the matching erase or a cancelling one, the pending unlock is used up.

Top module: `rev_guard_ctrl`

## Requirements
- R1: In per-revision mode, READ/VERIFY (code 1) is denied when the target revision's read-protect flag is set and granted otherwise. SET_RP (code 4) sets that flag and is always granted.
- R2: PROGRAM (code 2) is denied when the target revision's lock flag is set. A set read-protect flag does not block it.
- R3: ERASE (code 3) of a locked revision is denied unless an unlock is pending for that revision. A granted ERASE clears both the read-protect and lock flags of that revision only. SET_WP (code 5) sets the lock and is always granted.
- R4: After UNLOCK (code 6, always granted) for revision r, the next command alone decides the outcome. If it is ERASE of r, it is granted even when r is locked. Any other command cancels the pending unlock. Cycles with no command do not cancel it.
- R5: Each cycle with `cmd_valid` high produces, one cycle later, exactly one of `grant_o` or `deny_o` for one cycle. Without a command, both stay low. NOP (code 0) is granted.
- R6: A denied command leaves every protection flag unchanged.
- R7: In whole-array mode, SET_RP sets one global read-protect flag. While that flag is set, READ to any revision is denied, and a revision ERASE does not clear it. ERASE_ALL (code 7) is denied if any revision is locked. Otherwise it is granted and clears all flags, global included.
- R8: While `isp_active` is high, `cascade_en_o` is 1 and `cfg_drive_en_o` is 0. Otherwise `cascade_en_o` follows `cascade_in` and `cfg_drive_en_o` is 1.
- R9: Reset clears all flags. The flags keep their values across changes of `whole_mode` and `isp_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | Operation code |
| cmd_rev | input | 2 | Target revision index |
| whole_mode | input | 1 | Single global read-protect flag in use |
| isp_active | input | 1 | In-system programming in progress |
| cascade_in | input | 1 | Cascade-enable value in normal operation |
| grant_o | output | 1 | One-cycle pulse: previous command granted |
| deny_o | output | 1 | One-cycle pulse: previous command denied |
| cascade_en_o | output | 1 | Cascade-enable output |
| cfg_drive_en_o | output | 1 | Drive enable for the other configuration outputs |

## Verification
The flags are not visible at the ports, so a wrong flag shows up only when a later command probes it. It appears as a grant where a deny was due, or the reverse, one cycle after that probing command. An unlock machine stuck in `UL_ARMED` shows up as a granted erase of a locked revision after a cancelling command. One stuck in `UL_IDLE` shows up as a denied matching erase. The directed tests therefore follow every flag change with a READ, PROGRAM or ERASE that exposes it, and they check the result in the cycle right after that command.

// File: rtl/rg_pkg.sv
package rg_pkg;
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_READ      = 3'd1,
        CMD_PROG      = 3'd2,
        CMD_ERASE     = 3'd3,
        CMD_SET_RP    = 3'd4,
        CMD_SET_WP    = 3'd5,
        CMD_UNLOCK    = 3'd6,
        CMD_ERASE_ALL = 3'd7
    } cmd_e;

    typedef enum logic {
        UL_IDLE  = 1'b0,
        UL_ARMED = 1'b1
    } ul_state_e;
endpackage

// File: rtl/rg_unlock_fsm.sv
module rg_unlock_fsm
    import rg_pkg::*;
#(
    parameter int REV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [REV_W-1:0] cmd_rev,
    output logic             armed_o,
    output logic [REV_W-1:0] arm_rev_o
);
    ul_state_e        state_q, state_d;
    logic [REV_W-1:0] rev_q, rev_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
            rev_q   <= '0;
        end else begin
            state_q <= state_d;
            rev_q   <= rev_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        rev_d   = rev_q;
        if (cmd_valid) begin
            unique case (state_q)
                UL_IDLE, UL_ARMED: begin
                    if (cmd_code == CMD_UNLOCK) begin
                        state_d = UL_ARMED;   // arm
                        rev_d   = cmd_rev;
                    end else begin
                        state_d = UL_IDLE;    // disarm
                    end
                end
                default: state_d = UL_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        armed_o   = (state_q == UL_ARMED);
        arm_rev_o = rev_q;
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(state_q));
    // R4
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UL_ARMED && cmd_valid && cmd_code != CMD_UNLOCK) |=> state_q == UL_IDLE);
endmodule

// File: rtl/rg_prot_bank.sv
module rg_prot_bank #(
    parameter int NUM_REV = 4,
    localparam int REV_W  = $clog2(NUM_REV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REV_W-1:0]   rev,
    input  logic               set_rp,
    input  logic               set_grp,
    input  logic               set_wp,
    input  logic               clr_one,
    input  logic               clr_all,
    output logic [NUM_REV-1:0] rp_q,
    output logic [NUM_REV-1:0] wp_q,
    output logic               grp_q
);
    for (genvar i = 0; i < NUM_REV; i++) begin : g_rev
        logic hit;
        assign hit = (rev == REV_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rp_q[i] <= 1'b0;
                wp_q[i] <= 1'b0;
            end else if (clr_all || (clr_one && hit)) begin
                rp_q[i] <= 1'b0;
                wp_q[i] <= 1'b0;
            end else begin
                if (set_rp && hit) rp_q[i] <= 1'b1;
                if (set_wp && hit) wp_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       grp_q <= 1'b0;
        else if (clr_all) grp_q <= 1'b0;
        else if (set_grp) grp_q <= 1'b1;
    end
endmodule

// File: rtl/rev_guard_ctrl.sv
module rev_guard_ctrl
    import rg_pkg::*;
#(
    parameter int NUM_REV = 4,
    localparam int REV_W  = $clog2(NUM_REV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [REV_W-1:0] cmd_rev,
    input  logic             whole_mode,
    input  logic             isp_active,
    input  logic             cascade_in,
    output logic             grant_o,
    output logic             deny_o,
    output logic             cascade_en_o,
    output logic             cfg_drive_en_o
);
    logic               armed;
    logic [REV_W-1:0]   arm_rev;
    logic [NUM_REV-1:0] rp_q, wp_q;
    logic               grp_q;
    logic               ok, take;
    logic               rp_eff, wp_hit, arm_hit;

    rg_unlock_fsm #(.REV_W(REV_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_rev(cmd_rev), .armed_o(armed), .arm_rev_o(arm_rev)
    );

    always_comb begin
        rp_eff  = whole_mode ? grp_q : rp_q[cmd_rev];
        wp_hit  = wp_q[cmd_rev];
        arm_hit = armed && (arm_rev == cmd_rev);
        unique case (cmd_code)
            CMD_READ:      ok = !rp_eff;
            CMD_PROG:      ok = !wp_hit;
            CMD_ERASE:     ok = !wp_hit || arm_hit;
            CMD_ERASE_ALL: ok = ~|wp_q;
            default:       ok = 1'b1;
        endcase
        take = cmd_valid && ok;
    end

    rg_prot_bank #(.NUM_REV(NUM_REV)) i_bank (
        .clk(clk), .rst_n(rst_n), .rev(cmd_rev),
        .set_rp(take && cmd_code == CMD_SET_RP && !whole_mode),
        .set_grp(take && cmd_code == CMD_SET_RP && whole_mode),
        .set_wp(take && cmd_code == CMD_SET_WP),
        .clr_one(take && cmd_code == CMD_ERASE),
        .clr_all(take && cmd_code == CMD_ERASE_ALL),
        .rp_q(rp_q), .wp_q(wp_q), .grp_q(grp_q)
    );

    // verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
        end else begin
            grant_o <= take;
            deny_o  <= cmd_valid && !ok;
        end
    end

    // output control
    always_comb begin
        cascade_en_o   = isp_active ? 1'b1 : cascade_in;
        cfg_drive_en_o = !isp_active;
    end

    // R5
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (grant_o ^ deny_o));
    // R5
    no_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!grant_o && !deny_o));
    // R6
    deny_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> ($stable(rp_q) && $stable(wp_q) && $stable(grp_q)));
    // R3
    erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_ERASE) |=> (grant_o |-> !wp_q[$past(cmd_rev)]));
    // R8
    isp_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isp_active |-> (cascade_en_o && !cfg_drive_en_o));
endmodule

// File: tb/test_rev_guard_ctrl.sv
`timescale 1ns/1ps
module test_rev_guard_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] cmd_rev = 2'd0;
    logic       whole_mode = 1'b0;
    logic       isp_active = 1'b0;
    logic       cascade_in = 1'b0;
    logic       grant_o, deny_o, cascade_en_o, cfg_drive_en_o;
    int         checks = 0;
    int         errors = 0;

    localparam logic [2:0] NOP = 0, RD = 1, PG = 2, ER = 3, SRP = 4, SWP = 5, UL = 6, EA = 7;

    always #4 clk = ~clk;

    rev_guard_ctrl i_rev_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_rev(cmd_rev), .whole_mode(whole_mode), .isp_active(isp_active),
        .cascade_in(cascade_in), .grant_o(grant_o), .deny_o(deny_o),
        .cascade_en_o(cascade_en_o), .cfg_drive_en_o(cfg_drive_en_o)
    );

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // issue one command; verdict checked in the cycle after the edge
    task automatic cmd(string req, logic [2:0] c, logic [1:0] r, bit exp_grant);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_rev = r;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(req, {grant_o, deny_o}, exp_grant ? 2'b10 : 2'b01);
    endtask

    task automatic t_reset;
        check("R9 reset verdict", {grant_o, deny_o}, 2'b00);
        check("R8 reset outputs", {cascade_en_o, cfg_drive_en_o}, 2'b01);
        for (int r = 0; r < 4; r++) cmd("R9 clear after reset", RD, 2'(r), 1);
    endtask

    task automatic t_read_prot;
        cmd("R1 set_rp", SRP, 1, 1);
        cmd("R1 read protected", RD, 1, 0);
        cmd("R1 read other rev", RD, 2, 1);
        cmd("R2 prog despite rp", PG, 1, 1);
        cmd("R3 erase unlocked", ER, 1, 1);
        cmd("R3 rp cleared by erase", RD, 1, 1);
    endtask

    task automatic t_pulse;
        cmd("R5 nop granted", NOP, 0, 1);
        @(negedge clk);
        check("R5 single pulse", {grant_o, deny_o}, 2'b00);
    endtask

    task automatic t_lock;
        cmd("R3 set_wp", SWP, 0, 1);
        cmd("R1 set_rp", SRP, 0, 1);
        cmd("R2 prog locked", PG, 0, 0);
        cmd("R3 erase locked", ER, 0, 0);
        cmd("R6 rp kept after deny", RD, 0, 0);
        cmd("R6 wp kept after deny", PG, 0, 0);
        cmd("R3 erase other rev", ER, 3, 1);
        cmd("R3 rev0 still locked", PG, 0, 0);
    endtask

    task automatic t_unlock;
        cmd("R4 unlock", UL, 0, 1);
        repeat (3) @(negedge clk);
        cmd("R4 erase after idle gap", ER, 0, 1);
        cmd("R4 lock cleared", PG, 0, 1);
        cmd("R4 rp cleared", RD, 0, 1);
        cmd("R4 lock rev3", SWP, 3, 1);
        cmd("R4 unlock rev3", UL, 3, 1);
        cmd("R4 cancelling read", RD, 3, 1);
        cmd("R4 erase after cancel", ER, 3, 0);
        cmd("R4 unlock rev3 again", UL, 3, 1);
        cmd("R4 erase other rev cancels", ER, 1, 1);
        cmd("R4 erase after cancel 2", ER, 3, 0);
        cmd("R4 unlock rev2", UL, 2, 1);
        cmd("R4 wrong-rev erase", ER, 3, 0);
        cmd("R4 unlock rev3 final", UL, 3, 1);
        cmd("R4 matching erase", ER, 3, 1);
    endtask

    task automatic t_whole;
        whole_mode = 1'b1;
        cmd("R7 set global rp", SRP, 0, 1);
        cmd("R7 read rev3 denied", RD, 3, 0);
        cmd("R7 erase rev3", ER, 3, 1);
        cmd("R7 global survives rev erase", RD, 3, 0);
        cmd("R7 lock rev1", SWP, 1, 1);
        cmd("R7 erase_all locked", EA, 0, 0);
        cmd("R6 global kept", RD, 0, 0);
        cmd("R7 unlock rev1", UL, 1, 1);
        cmd("R7 erase rev1", ER, 1, 1);
        cmd("R7 erase_all", EA, 0, 1);
        cmd("R7 global cleared", RD, 2, 1);
        whole_mode = 1'b0;
    endtask

    task automatic t_isp;
        @(negedge clk);
        isp_active = 1'b1; cascade_in = 1'b0;
        #1 check("R8 isp outputs", {cascade_en_o, cfg_drive_en_o}, 2'b10);
        cmd("R9 set_rp in isp", SRP, 2, 1);
        @(negedge clk);
        isp_active = 1'b0;
        #1 check("R8 normal cascade low", {cascade_en_o, cfg_drive_en_o}, 2'b01);
        cascade_in = 1'b1;
        #1 check("R8 normal cascade high", {cascade_en_o, cfg_drive_en_o}, 2'b11);
        cmd("R9 rp kept after isp", RD, 2, 0);
        whole_mode = 1'b1;
        @(negedge clk);
        whole_mode = 1'b0;
        cmd("R9 rp kept after mode", RD, 2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_prot();
        t_pulse();
        t_lock();
        t_unlock();
        t_whole();
        t_isp();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule